// File: doc/BRIEF.md
# Conditional Interrupt, Branch and Wait Evaluator

This block sits beside a descriptor-processing engine. When the engine has a descriptor in hand, it pulses an evaluate strobe. The block then makes three decisions for that descriptor: whether to raise an interrupt, whether to take a branch, and whether the engine must stall in a wait.

Each decision has its own 2-bit policy field in the command word. Each also has its own select register, which carries a mask and a match value. The block compares the low device-status bits against the match value, through the mask, and the policy then turns that compare result into a decision.

Three outputs carry the decisions:
- The interrupt is a single-cycle pulse.
- The branch decision is held until the next evaluation.
- The wait hold keeps being re-checked against live device status every cycle, so the stall ends as soon as the status changes.

Top module: `cond_eval`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it until the first evaluate strobe, `irq_o`, `br_take_o` and `wait_hold_o` are 0.
- R2: The interrupt policy is `pol_i[5:4]` and uses `int_sel_i`. `irq_o` is 1 for exactly the one cycle after an evaluate strobe, and only if the policy fires.
- R3: The branch policy is `pol_i[3:2]` and uses `br_sel_i`. `br_take_o` takes its decision in the cycle after the strobe and holds it until the next strobe.
- R4: The wait policy is `pol_i[1:0]` and uses `wait_sel_i`. `wait_hold_o` takes its decision in the cycle after the strobe.
- R5: Each policy field is encoded as follows: 0 never acts, 1 acts when the condition is true, 2 acts when the condition is false, 3 always acts.
- R6: The condition is true when (status[3:0] AND mask) equals (value AND mask). The mask is select bits [19:16] and the value is select bits [3:0]. A zero mask makes the condition true.
- R7: Each decision uses only its own select register. Different select contents can give different results in the same evaluation.
- R8: While `wait_hold_o` is 1 and no strobe arrives, the wait decision is recomputed every cycle from the live status. Once it drops to 0, it stays 0 until the next strobe.
- R9: Status bits [7:4], and select bits outside [19:16] and [3:0], have no effect on any decision.
- R10: Without a strobe, changes on `pol_i` or on the select inputs do not change `br_take_o` and do not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Evaluate strobe from the engine |
| pol_i | input | 6 | Policy fields: interrupt [5:4], branch [3:2], wait [1:0] |
| dev_stat_i | input | 8 | Device-status field |
| int_sel_i | input | 32 | Interrupt select: mask [19:16], value [3:0] |
| br_sel_i | input | 32 | Branch select: mask [19:16], value [3:0] |
| wait_sel_i | input | 32 | Wait select: mask [19:16], value [3:0] |
| irq_o | output | 1 | Interrupt pulse |
| br_take_o | output | 1 | Branch decision |
| wait_hold_o | output | 1 | Wait stall hold |

## Verification
Every output is registered once. All three decisions are therefore visible in the cycle after the clock edge that samples the strobe, and the interrupt pulse has dropped one cycle after that. The wait release follows a status change by exactly one edge. The bench drives inputs on the falling edge and samples on the following falling edge, so each check lands on the first cycle in which the result is due. The pulse width and the branch hold are checked again one and several cycles later.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int STAT_W   = 8,
  parameter int SEL_W    = 32,
  parameter int CMP_W    = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [5:0]        pol_i,
  input  logic [STAT_W-1:0] dev_stat_i,
  input  logic [SEL_W-1:0]  int_sel_i,
  input  logic [SEL_W-1:0]  br_sel_i,
  input  logic [SEL_W-1:0]  wait_sel_i,
  output logic              irq_o,
  output logic              br_take_o,
  output logic              wait_hold_o
);
  localparam int POL_W = 2;

  function automatic logic hit(input logic [STAT_W-1:0] st, input logic [SEL_W-1:0] sel);
    logic [CMP_W-1:0] m;
    m = sel[MASK_LSB +: CMP_W];
    return (st[CMP_W-1:0] & m) == (sel[CMP_W-1:0] & m);
  endfunction

  function automatic logic act(input logic [POL_W-1:0] p, input logic c);
    case (p)
      2'd1:    return c;
      2'd2:    return !c;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic c_int, c_br, c_wait;
  assign c_int  = hit(dev_stat_i, int_sel_i);
  assign c_br   = hit(dev_stat_i, br_sel_i);
  assign c_wait = hit(dev_stat_i, wait_sel_i);

  logic unused_bits;
  assign unused_bits = ^{dev_stat_i, int_sel_i, br_sel_i, wait_sel_i};

  logic             irq_q, br_q, wait_q;
  logic [POL_W-1:0] wpol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      br_q   <= 1'b0;
      wait_q <= 1'b0;
      wpol_q <= '0;
    end else begin
      irq_q <= eval_i && act(pol_i[5:4], c_int);
      if (eval_i) begin
        br_q   <= act(pol_i[3:2], c_br);
        wait_q <= act(pol_i[1:0], c_wait);
        wpol_q <= pol_i[1:0];
      end else if (wait_q) begin
        wait_q <= act(wpol_q, c_wait);
      end
    end
  end

  assign irq_o       = irq_q;
  assign br_take_o   = br_q;
  assign wait_hold_o = wait_q;
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eval_i,
  input logic [5:0] pol_i,
  input logic       irq_o,
  input logic       br_take_o,
  input logic       wait_hold_o
);
  // R2: a pulse only follows a strobe
  a_r2_irq_after_eval: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(eval_i));
  // R2 / R5: an always-interrupt policy fires
  a_r2_irq_always: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && pol_i[5:4] == 2'd3) |=> irq_o);
  // R3 / R5: an always-branch policy takes the branch
  a_r3_br_always: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && pol_i[3:2] == 2'd3) |=> br_take_o);
  // R4 / R5: a never-wait policy does not stall
  a_r4_wait_never: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && pol_i[1:0] == 2'd0) |=> !wait_hold_o);
  // R8: a hold can only begin on a strobe
  a_r8_wait_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_hold_o) |-> $past(eval_i));
  // R10: the branch decision holds between strobes
  a_r10_br_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(eval_i)) |-> $stable(br_take_o));
endmodule

bind cond_eval cond_eval_chk u_chk (.*);

// File: tb/sim_cond_eval.sv
`timescale 1ns/1ps
module sim_cond_eval;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        eval_i = 0;
  logic [5:0]  pol_i = 0;
  logic [7:0]  dev_stat_i = 0;
  logic [31:0] int_sel_i = 0, br_sel_i = 0, wait_sel_i = 0;
  logic        irq_o, br_take_o, wait_hold_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_eval u0 (.*);

  function automatic bit m_cond(logic [7:0] s, logic [31:0] sel);
    return (s[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16]);
  endfunction

  function automatic bit m_act(logic [1:0] p, bit c);
    return (p == 2'd3) || (p == 2'd1 && c) || (p == 2'd2 && !c);
  endfunction

  function automatic logic [31:0] mk_sel(logic [3:0] m, logic [3:0] v);
    return {12'h0, m, 12'h0, v};
  endfunction

  task automatic check(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic fire(logic [5:0] p, logic [7:0] s, logic [31:0] is, logic [31:0] bs, logic [31:0] ws);
    @(negedge clk);
    pol_i = p; dev_stat_i = s; int_sel_i = is; br_sel_i = bs; wait_sel_i = ws;
    eval_i = 1;
    @(negedge clk);
    eval_i = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq_o, 0);
    check("R1 br in reset", br_take_o, 0);
    check("R1 wait in reset", wait_hold_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 br after reset", br_take_o, 0);
    check("R1 wait after reset", wait_hold_o, 0);
  endtask

  task automatic t_policies;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] sel;
        sel = mk_sel(4'hF, c ? 4'h5 : 4'hA);
        fire({p[1:0], p[1:0], p[1:0]}, 8'h05, sel, sel, sel);
        check("R2 R5 irq policy", irq_o, m_act(p[1:0], m_cond(8'h05, sel)));
        check("R3 R5 branch policy", br_take_o, m_act(p[1:0], m_cond(8'h05, sel)));
        check("R4 R5 wait policy", wait_hold_o, m_act(p[1:0], m_cond(8'h05, sel)));
        @(negedge clk);
        check("R2 irq one cycle", irq_o, 0);
        repeat (3) @(negedge clk);
        check("R3 branch held", br_take_o, m_act(p[1:0], m_cond(8'h05, sel)));
      end
    end
  endtask

  task automatic t_mask;
    fire(6'b01_01_01, 8'h0C, mk_sel(4'h0, 4'h3), mk_sel(4'h1, 4'h0), mk_sel(4'h8, 4'h0));
    check("R6 zero mask true", irq_o, 1);
    check("R6 bit0 match", br_take_o, 1);
    check("R6 bit3 mismatch", wait_hold_o, 0);
  endtask

  task automatic t_indep;
    fire(6'b01_01_01, 8'h06, mk_sel(4'hF, 4'h6), mk_sel(4'hF, 4'h7), mk_sel(4'h6, 4'hE));
    check("R7 int uses own select", irq_o, 1);
    check("R7 br uses own select", br_take_o, 0);
    check("R7 wait uses own select", wait_hold_o, 1);
  endtask

  task automatic t_release;
    fire(6'b00_00_01, 8'h03, 0, 0, mk_sel(4'h3, 4'h3));
    check("R8 hold set", wait_hold_o, 1);
    @(negedge clk);
    dev_stat_i = 8'h13;
    @(negedge clk);
    check("R8 hold kept", wait_hold_o, 1);
    dev_stat_i = 8'h01;
    @(negedge clk);
    check("R8 released", wait_hold_o, 0);
    dev_stat_i = 8'h03;
    repeat (2) @(negedge clk);
    check("R8 stays released", wait_hold_o, 0);
    fire(6'b00_00_10, 8'h03, 0, 0, mk_sel(4'h3, 4'h0));
    check("R8 ifclr hold", wait_hold_o, 1);
    dev_stat_i = 8'h00;
    @(negedge clk);
    check("R8 ifclr release", wait_hold_o, 0);
  endtask

  task automatic t_ignore;
    fire(6'b01_01_01, 8'hF5, 32'hFFF0_FFF5 & 32'hFFFF_FFF5, 32'hABC5_1235, 32'h7F0F_00F5);
    check("R9 int ignores extra bits", irq_o, 1);
    check("R9 br ignores extra bits", br_take_o, 1);
    check("R9 wait ignores extra bits", wait_hold_o, 1);
  endtask

  task automatic t_no_eval;
    fire(6'b00_00_00, 8'h00, 0, 0, 0);
    check("R10 br cleared", br_take_o, 0);
    @(negedge clk);
    pol_i = 6'b11_11_11; br_sel_i = mk_sel(4'h0, 4'h0);
    repeat (3) @(negedge clk);
    check("R10 br unchanged", br_take_o, 0);
    check("R10 no irq", irq_o, 0);
    check("R10 no wait", wait_hold_o, 0);
  endtask

  initial begin
    t_reset();
    t_policies();
    t_mask();
    t_indep();
    t_release();
    t_ignore();
    t_no_eval();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule